// File: doc/BRIEF.md
# Priority Arbiter with Starvation Escalation

This block decides, every clock cycle, which of several requesters may use one shared memory or bus resource. Each requester raises a request bit and, alongside it, a priority field that belongs to that transfer alone, so the same requester may ask at different levels from one transfer to the next. The arbiter is strict-priority: the lowest level number wins, and ties go to the lowest requester index. A per-requester mask can pin a requester to a level above every normal level.

Strict priority alone can lock a low-priority requester out for as long as a higher one keeps asking. To bound that wait, a contention counter counts arbitration cycles in which more than one requester asked. When it reaches a programmable limit n, the requester that has waited longest is lifted to the top level for one arbitration. It then gets one grant in every n contended cycles. Writing n = 0 switches this escalation off.

The grant is a registered one-hot vector that is high for one cycle per arbitration. An escalation flag is high in the same cycle when that grant came from escalation. There is no back-pressure: a request is a level that the requester holds until it sees its grant bit. The grant is the only acknowledgement, and a requester that is not granted simply asks again in the next cycle.

Top module: `prio_arbiter`

## Requirements
- R1: During synchronous reset and in the cycle after it, `gnt` and `gnt_esc` are 0. The contention limit resets to `DEF_LIMIT` (4).
- R2: A request pattern presented in cycle t gives its grant in cycle t+1. `gnt` is zero or one-hot, it never grants a requester whose `req` bit was low in cycle t, and it is all zero when no request was present.
- R3: The 4-bit priority field of requester i sits in `prio[4*i+3:4*i]`. Values 0..8 are levels 0..8, where 0 is the highest. Values 9..15 act as level 8. The lowest level number wins.
- R4: Among requesters at the same effective level, the lowest index wins.
- R5: A requester whose `fix_top` bit is set is at the top level, above level 0. Among several such requesters, the lowest index wins.
- R6: The contention counter adds one in each cycle with two or more requests, saturating at its maximum. It returns to 0 in any cycle with fewer than two requests, and in any cycle whose grant is escalated.
- R7: An escalation is attempted in a contended cycle when n != 0 and the counter is at least n-1. The candidate must be requesting and not fixed-top. It must have been denied in the previous cycle while requesting, so its wait count is nonzero, and it must not be the plain strict-priority winner. Among candidates, the largest wait count wins, and the lowest index breaks ties. The wait count of a requester clears when it is granted or stops requesting. The candidate joins the top level and competes with fixed-top requesters by index.
- R8: `gnt_esc` is 1 exactly in the cycle whose grant went to an escalated candidate. It is never set without a grant and never set for a fixed-top requester.
- R9: With n = 0, no escalation occurs and the arbiter is pure strict priority.
- R10: A write through `cfg_we` and `cfg_limit` takes effect from the next arbitration. With n = 1, an escalation is attempted in every contended cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_REQ | Request bit per requester |
| prio | input | NUM_REQ*PRIO_W | Per-transfer priority field per requester |
| fix_top | input | NUM_REQ | Pins a requester above all normal levels |
| cfg_we | input | 1 | Write strobe for the contention limit |
| cfg_limit | input | CNT_W | New contention limit n (0 disables escalation) |
| gnt | output | NUM_REQ | Registered one-hot grant |
| gnt_esc | output | 1 | Grant in this cycle came from escalation |

## Verification
Every grant and escalation flag is due one clock after the request pattern that caused it. A limit write first affects the arbitration in the cycle after the write. The bench drives inputs on the falling edge. At each later falling edge, it first compares the registered outputs with the result its model computed for the previous pattern, and only then drives the next pattern. The model keeps its own contention counter and wait ages, so a comparison at a falling edge always refers to exactly one earlier decision.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVL_MAX = 8;
  localparam int LVL_W   = 4;
  // Encoded level: 0 = top (above level 0), 1..9 = levels 0..8, 10 = no request
  localparam logic [LVL_W-1:0] LVL_TOP  = '0;
  localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(LVL_MAX + 2);

  function automatic logic [LVL_W-1:0] enc_level(input int unsigned p);
    if (p > LVL_MAX) return LVL_W'(LVL_MAX + 1);
    return LVL_W'(p + 1);
  endfunction
endpackage

// File: rtl/arb_lvl_map.sv
module arb_lvl_map
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_REQ-1:0]        req,
  input  logic [NUM_REQ*PRIO_W-1:0] prio,
  input  logic [NUM_REQ-1:0]        fix_top,
  output logic [NUM_REQ*LVL_W-1:0]  lvl_o
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_map
    assign lvl_o[i*LVL_W +: LVL_W] = !req[i]    ? LVL_NONE :
                                     fix_top[i] ? LVL_TOP  :
                                     enc_level(32'(prio[i*PRIO_W +: PRIO_W]));
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ*LVL_W-1:0] lvl_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [LVL_W-1:0] best;

  always_comb begin
    best  = LVL_NONE;
    idx_o = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (lvl_i[i*LVL_W +: LVL_W] < best) begin
        best  = lvl_i[i*LVL_W +: LVL_W];
        idx_o = IDX_W'(i);
      end
    end
    valid_o = (best != LVL_NONE);
  end
endmodule

// File: rtl/arb_starve.sv
module arb_starve #(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] fix_top,
  input  logic [CNT_W-1:0]   limit,
  input  logic               norm_valid,
  input  logic [IDX_W-1:0]   norm_idx,
  input  logic               fin_valid,
  input  logic [IDX_W-1:0]   fin_idx,
  input  logic               esc_taken,
  output logic               cand_valid,
  output logic [IDX_W-1:0]   cand_idx,
  output logic               esc_fire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] age_q [NUM_REQ];
  logic [CNT_W-1:0] best_age;
  logic             contended;

  assign contended = ($countones(req) >= 2);
  assign esc_fire  = (limit != '0) && contended && (cnt_q >= limit - CNT_W'(1));

  // oldest waiting requester that strict priority would not serve
  always_comb begin
    best_age = '0;
    cand_idx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i] && !fix_top[i] && !(norm_valid && norm_idx == IDX_W'(i)) &&
          age_q[i] > best_age) begin
        best_age = age_q[i];
        cand_idx = IDX_W'(i);
      end
    end
    cand_valid = (best_age != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!contended || esc_taken) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[i] <= '0;
      end else if (req[i] && !(fin_valid && fin_idx == IDX_W'(i))) begin
        if (age_q[i] != '1) age_q[i] <= age_q[i] + CNT_W'(1);
      end else begin
        age_q[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int PRIO_W    = 4,
  parameter int CNT_W     = 8,
  parameter int DEF_LIMIT = 4,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REQ-1:0]        req,
  input  logic [NUM_REQ*PRIO_W-1:0] prio,
  input  logic [NUM_REQ-1:0]        fix_top,
  input  logic                      cfg_we,
  input  logic [CNT_W-1:0]          cfg_limit,
  output logic [NUM_REQ-1:0]        gnt,
  output logic                      gnt_esc
);
  logic [NUM_REQ*LVL_W-1:0] lvl_norm, lvl_fin;
  logic                     norm_valid, fin_valid, cand_valid, esc_fire, esc_taken;
  logic [IDX_W-1:0]         norm_idx, fin_idx, cand_idx;
  logic [CNT_W-1:0]         limit_q;

  arb_lvl_map #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) u_map (
    .req(req), .prio(prio), .fix_top(fix_top), .lvl_o(lvl_norm)
  );

  arb_pick #(.NUM_REQ(NUM_REQ)) u_pick_norm (
    .lvl_i(lvl_norm), .valid_o(norm_valid), .idx_o(norm_idx)
  );

  arb_starve #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_starve (
    .clk(clk), .rst(rst), .req(req), .fix_top(fix_top), .limit(limit_q),
    .norm_valid(norm_valid), .norm_idx(norm_idx),
    .fin_valid(fin_valid), .fin_idx(fin_idx), .esc_taken(esc_taken),
    .cand_valid(cand_valid), .cand_idx(cand_idx), .esc_fire(esc_fire)
  );

  // lift the candidate to the top level for this arbitration
  always_comb begin
    lvl_fin = lvl_norm;
    if (esc_fire && cand_valid) lvl_fin[cand_idx*LVL_W +: LVL_W] = LVL_TOP;
  end

  arb_pick #(.NUM_REQ(NUM_REQ)) u_pick_fin (
    .lvl_i(lvl_fin), .valid_o(fin_valid), .idx_o(fin_idx)
  );

  assign esc_taken = esc_fire && cand_valid && fin_valid && (fin_idx == cand_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt     <= '0;
      gnt_esc <= 1'b0;
      limit_q <= CNT_W'(DEF_LIMIT);
    end else begin
      if (cfg_we) limit_q <= cfg_limit;
      gnt     <= fin_valid ? (NUM_REQ'(1) << fin_idx) : '0;
      gnt_esc <= esc_taken;
    end
  end
endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req,
  input logic [NUM_REQ-1:0] fix_top,
  input logic [CNT_W-1:0]   limit_q,
  input logic [NUM_REQ-1:0] gnt,
  input logic               gnt_esc
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (gnt == '0));

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    a_r2_only_req: assert property (@(posedge clk) disable iff (rst)
      !req[i] |=> !gnt[i]);
  end

  a_r8_esc_has_gnt: assert property (@(posedge clk) disable iff (rst)
    gnt_esc |-> (gnt != '0));

  a_r8_esc_not_fixed: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> !(gnt_esc && ((gnt & $past(fix_top)) != '0)));

  a_r9_no_esc_when_off: assert property (@(posedge clk) disable iff (rst)
    (limit_q == '0) |=> !gnt_esc);

  a_r5_fixed_wins: assert property (@(posedge clk) disable iff (rst)
    (((req & fix_top) != '0) && (limit_q == '0)) |=> ((gnt & $past(fix_top)) != '0));
endmodule

bind prio_arbiter prio_arbiter_chk #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .fix_top(fix_top), .limit_q(limit_q),
  .gnt(gnt), .gnt_esc(gnt_esc)
);

// File: tb/tb_prio_arbiter.sv
module tb_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int PW = 4;
  localparam int CW = 8;
  localparam int CMAX = 255;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req;
  logic [N*PW-1:0] prio;
  logic [N-1:0]  fix_top;
  logic          cfg_we;
  logic [CW-1:0] cfg_limit;
  logic [N-1:0]  gnt;
  logic          gnt_esc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  int m_cnt, m_lim;
  int m_age [N];
  logic [N-1:0] exp_gnt;
  logic exp_esc;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_arbiter #(.NUM_REQ(N), .PRIO_W(PW), .CNT_W(CW), .DEF_LIMIT(4)) dut (
    .clk(clk), .rst(rst), .req(req), .prio(prio), .fix_top(fix_top),
    .cfg_we(cfg_we), .cfg_limit(cfg_limit), .gnt(gnt), .gnt_esc(gnt_esc)
  );

  function automatic int lvl_of(logic r, logic f, int p);
    if (!r) return 99;
    if (f) return -1;
    return (p > 8) ? 8 : p;
  endfunction

  function automatic int pick(int l [N]);
    int best = 99;
    int idx = -1;
    for (int i = 0; i < N; i++) if (l[i] < best) begin best = l[i]; idx = i; end
    return idx;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (gnt !== exp_gnt || gnt_esc !== exp_esc) begin
      n_fail++;
      $display("FAIL %s: gnt=%b esc=%b expected gnt=%b esc=%b", tag, gnt, gnt_esc, exp_gnt, exp_esc);
    end
  endtask

  // called at a falling edge: check previous decision, then apply new pattern
  task automatic step(string tag, logic [N-1:0] r, logic [N*PW-1:0] p, logic [N-1:0] f,
                      logic we, int lv);
    int l [N];
    int nw, fw, cand, best, cnt_req;
    bit fire, esc;
    check(exp_tag);
    cnt_req = 0;
    for (int i = 0; i < N; i++) begin
      l[i] = lvl_of(r[i], f[i], int'(p[i*PW +: PW]));
      if (r[i]) cnt_req++;
    end
    nw = pick(l);
    fire = (m_lim != 0) && (cnt_req >= 2) && (m_cnt >= m_lim - 1);
    cand = -1; best = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && !f[i] && i != nw && m_age[i] > best) begin best = m_age[i]; cand = i; end
    if (fire && cand >= 0) l[cand] = -1;
    fw = pick(l);
    esc = fire && cand >= 0 && fw == cand;
    exp_gnt = (fw >= 0) ? N'(1 << fw) : '0;
    exp_esc = esc;
    exp_tag = tag;
    if (cnt_req < 2 || esc) m_cnt = 0;
    else if (m_cnt < CMAX) m_cnt++;
    for (int i = 0; i < N; i++)
      if (r[i] && fw != i) begin if (m_age[i] < CMAX) m_age[i]++; end
      else m_age[i] = 0;
    if (we) m_lim = lv;
    req = r; prio = p; fix_top = f; cfg_we = we; cfg_limit = CW'(lv);
    @(negedge clk);
  endtask

  function automatic logic [N*PW-1:0] pv(int p3, int p2, int p1, int p0);
    return {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    rst = 1; req = '0; prio = '0; fix_top = '0; cfg_we = 0; cfg_limit = '0;
    repeat (3) @(negedge clk);
    // R1: outputs clear in reset
    n_chk++;
    if (gnt !== '0 || gnt_esc !== 1'b0) begin
      n_fail++; $display("FAIL R1: gnt=%b esc=%b expected 0 0", gnt, gnt_esc);
    end
    rst = 0;
    m_cnt = 0; m_lim = 4; exp_gnt = '0; exp_esc = 0; exp_tag = "R1";
    for (int i = 0; i < N; i++) m_age[i] = 0;
    @(negedge clk);
    // R1: default limit 4 -> escalation on the fourth contended cycle
    for (int k = 0; k < 8; k++) step("R1", 4'b1001, pv(6,0,0,0), '0, 0, 0);
    step("R2", 4'b0000, '0, '0, 0, 0);
    // R3: lower number wins; 9..15 clamp to 8
    step("R3", 4'b0011, pv(0,0,2,5), '0, 0, 0);
    step("R3", 4'b0000, '0, '0, 0, 0);
    step("R3", 4'b0011, pv(0,0,9,15), '0, 0, 0);
    step("R3", 4'b0000, '0, '0, 0, 0);
    step("R3", 4'b0110, pv(0,8,15,0), '0, 0, 0);
    step("R3", 4'b0000, '0, '0, 0, 0);
    // R4: tie goes to lowest index
    step("R4", 4'b1110, pv(3,3,3,0), '0, 0, 0);
    step("R4", 4'b0000, '0, '0, 0, 0);
    // R5: fixed-top beats level 0
    step("R5", 4'b1001, pv(7,0,0,0), 4'b1000, 0, 0);
    step("R5", 4'b1100, pv(0,0,0,0), 4'b1100, 0, 0);
    step("R5", 4'b0000, '0, '0, 0, 0);
    // R9: n = 0 is pure strict priority
    step("R9", 4'b0000, '0, '0, 1, 0);
    for (int k = 0; k < 8; k++) step("R9", 4'b0101, pv(0,7,0,0), '0, 0, 0);
    step("R9", 4'b0000, '0, '0, 0, 0);
    // R10: n = 1 escalates every contended cycle
    step("R10", 4'b0000, '0, '0, 1, 1);
    for (int k = 0; k < 8; k++) step("R10", 4'b0101, pv(0,7,0,0), '0, 0, 0);
    step("R10", 4'b0000, '0, '0, 0, 0);
    // R7/R8: several starved requesters, oldest first
    step("R7", 4'b0000, '0, '0, 1, 3);
    for (int k = 0; k < 12; k++) step("R7", 4'b1110, pv(4,4,0,0), '0, 0, 0);
    step("R8", 4'b1011, pv(5,0,0,0), 4'b0001, 0, 0);
    for (int k = 0; k < 6; k++) step("R8", 4'b1011, pv(5,0,0,0), 4'b0001, 0, 0);
    // R6: a quiet cycle resets the counter
    step("R6", 4'b0000, '0, '0, 1, 3);
    step("R6", 4'b0011, pv(0,0,5,0), '0, 0, 0);
    step("R6", 4'b0011, pv(0,0,5,0), '0, 0, 0);
    step("R6", 4'b0001, pv(0,0,5,0), '0, 0, 0);
    for (int k = 0; k < 4; k++) step("R6", 4'b0011, pv(0,0,5,0), '0, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r = N'($urandom);
      logic [N*PW-1:0] p = (N*PW)'($urandom);
      logic [N-1:0] f = ($urandom % 8 == 0) ? N'($urandom) : '0;
      logic we = ($urandom % 40 == 0);
      int lv = int'($urandom % 6);
      if ($urandom % 2 == 0) r = r | 4'b0011;
      step("R2", r, p, f, we, lv);
    end
    step("R2", 4'b0000, '0, '0, 0, 0);
    check(exp_tag);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule